// File: doc/BRIEF.md
# Multi-master I2C bus-busy tracker

This block listens to the SDA and SCL wires of an I2C bus that several masters share. It keeps a busy flag that tells a local controller whether another master currently owns the bus. It also keeps a sticky flag that records that a STOP was seen. Both lines first pass through a synchronizer and then a stability filter. START, STOP and acknowledge-like conditions are taken from the filtered levels.

After the block is enabled, or after a soft-reset pulse, the busy flag is loaded from the line levels present at that moment. That value can be wrong if another master is in the middle of a transfer, so the flag is not trusted at first. A separate validity output rises once the tracker has seen real bus activity, or once both lines have stayed high for a programmable idle interval. The interval defaults to the number of cycles in 10 ms. If validity is not reached within a longer overall timeout, an error output rises and validity stays low until the next soft reset or enable. A local controller should start a transfer only when validity is high and busy is low.

Top module: `i2c_bus_watch`

## Requirements
- R1: While `en` is low, all four outputs are 0 and line activity has no effect on them.
- R2: On the first cycle after `en` rises, or after a `soft_rst` pulse, `busy` is loaded as 1 when filtered SDA is 0 and SCL is 1. It is loaded as 0 for the other three level combinations.
- R3: SDA falling while SCL stays high (START) sets `busy` to 1.
- R4: SDA low while SCL is high sets `busy` to 1 even when no START was seen, as during an acknowledge.
- R5: SDA rising while SCL stays high (STOP) clears `busy` and sets `bus_free_event`.
- R6: `bus_free_event` stays at 1 until a `free_clr` pulse clears it. When `free_clr` and a STOP fall in the same cycle, the flag ends up at 1.
- R7: `soft_rst` clears `busy_valid`, `valid_timeout` and `bus_free_event`.
- R8: `busy_valid` rises once a busy-setting condition or a STOP has been seen after the seed.
- R9: `busy_valid` rises after both lines have been high for IDLE_CYC consecutive cycles with no activity.
- R10: If either line goes low before the idle interval completes, the idle count restarts from zero.
- R11: If `busy_valid` is not reached within TMO_CYC cycles of the seed, `valid_timeout` rises. `busy_valid` then stays 0 until the next `soft_rst` or enable, while `busy` keeps tracking the bus.
- R12: When SDA and SCL change in the same filtered cycle, the change counts as neither START nor STOP.
- R13: A raw line change is accepted after SYNC_STAGES plus FILT_LEN cycles, so `busy` reacts one cycle later. A raw pulse shorter than FILT_LEN cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low holds all outputs at 0 |
| soft_rst | input | 1 | One-cycle pulse that re-seeds busy and restarts validation |
| sda_in | input | 1 | Raw SDA level from the bus |
| scl_in | input | 1 | Raw SCL level from the bus |
| free_clr | input | 1 | Write-one-to-clear pulse for bus_free_event |
| busy | output | 1 | Another master owns the bus |
| bus_free_event | output | 1 | Sticky flag: a STOP was seen |
| busy_valid | output | 1 | busy can be trusted |
| valid_timeout | output | 1 | Validation did not complete within TMO_CYC cycles |

## Verification
The bench seeds the tracker from all four line combinations. A design that decoded the seed wrongly would report a busy bus as free and let a transfer collide with another master.

The idle interval is broken part-way by a low pulse on SCL. A counter that paused instead of restarting would grant validity early. The bench also drives a timeout case and then produces activity. A design that kept validating after the error would wrongly raise `busy_valid`.

Several other stimuli each catch a specific defect:
- A clear pulse timed to land in the same cycle as a STOP catches a clear-wins priority.
- A one-cycle SDA glitch catches missing filtering, which would set `busy` spuriously.
- A simultaneous change of both lines catches a design that mistakes it for START or STOP.
- An SCL rise while SDA is already low catches a design that only looks for START edges.
- A sample taken one cycle before the expected latency catches a pipeline that is too short or too long.

// File: rtl/bbw_pkg.sv
package bbw_pkg;

    localparam int LINE_SDA = 0;
    localparam int LINE_SCL = 1;
    localparam int NUM_LINES = 2;

    // Tracker state held in the top module
    typedef struct packed {
        logic busy;
        logic free_evt;
        logic seed_pend;
    } trk_state_t;

    // Bus conditions decoded from filtered lines
    typedef struct packed {
        logic start;
        logic stop;
        logic hold_low;
        logic both_high;
    } bus_cond_t;

endpackage

// File: rtl/bbw_line_filter.sv
module bbw_line_filter #(
    parameter int  SYNC_STAGES = 2,
    parameter int  FILT_LEN    = 3,
    parameter logic RST_VAL    = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   out;
    } flt_state_t;

    flt_state_t st_d, st_q;
    logic sampled;

    assign sampled = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], din};
        if (sampled != st_q.out) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.out = sampled;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sync <= {SYNC_STAGES{RST_VAL}};
            st_q.cnt  <= '0;
            st_q.out  <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.out;

    AST_FILT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sampled == dout) |=> (dout == $past(dout)))
        else $error("filtered line moved without a differing sample"); // R13

    AST_FILT_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_LAST)
        else $error("filter count past limit"); // R13

endmodule

// File: rtl/bbw_cond_detect.sv
module bbw_cond_detect
    import bbw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sda,
    input  logic      scl,
    output bus_cond_t cond
);

    typedef struct packed {
        logic sda_prev;
        logic scl_prev;
    } det_state_t;

    det_state_t st_d, st_q;

    always_comb begin
        st_d.sda_prev = sda;
        st_d.scl_prev = scl;
        // SCL must be high in both samples for an edge on SDA to count
        cond.start     = st_q.scl_prev && scl && st_q.sda_prev && !sda;
        cond.stop      = st_q.scl_prev && scl && !st_q.sda_prev && sda;
        cond.hold_low  = scl && !sda;
        cond.both_high = scl && sda;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sda_prev <= 1'b1;
            st_q.scl_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_START_NEEDS_HIGH_SCL: assert property (@(posedge clk) disable iff (rst)
        cond.start |-> ($past(scl) && $past(sda)))
        else $error("START without prior high lines"); // R12

    AST_STOP_NEEDS_HIGH_SCL: assert property (@(posedge clk) disable iff (rst)
        cond.stop |-> ($past(scl) && !$past(sda)))
        else $error("STOP without prior high SCL and low SDA"); // R12

endmodule

// File: rtl/bbw_valid_ctrl.sv
module bbw_valid_ctrl #(
    parameter int IDLE_CYC = 1_000_000,
    parameter int TMO_CYC  = 2_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic activity,
    input  logic both_high,
    output logic valid,
    output logic tmo_err
);

    localparam int IW = $clog2(IDLE_CYC + 1);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);
    localparam logic [TW-1:0] TMO_LAST  = TW'(TMO_CYC - 1);

    typedef struct packed {
        logic          valid;
        logic          err;
        logic [IW-1:0] idle_cnt;
        logic [TW-1:0] tmo_cnt;
    } vc_state_t;

    vc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (run && !st_q.valid && !st_q.err) begin
            if (activity) begin
                st_d.valid = 1'b1;
            end else if (both_high) begin
                if (st_q.idle_cnt == IDLE_LAST) begin
                    st_d.valid = 1'b1;
                end else begin
                    st_d.idle_cnt = st_q.idle_cnt + 1'b1;
                end
            end else begin
                st_d.idle_cnt = '0;
            end
            // Validity wins over the timeout in the same cycle
            if (!st_d.valid) begin
                if (st_q.tmo_cnt == TMO_LAST) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.tmo_cnt = st_q.tmo_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid   = st_q.valid;
    assign tmo_err = st_q.err;

    AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(valid && tmo_err))
        else $error("valid and timeout both high"); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (tmo_err && !clear) |=> (tmo_err && !valid))
        else $error("timeout state left without clear"); // R11

    AST_CLEAR_RESETS: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!valid && !tmo_err))
        else $error("clear did not drop validity"); // R7

    AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (run && !clear && !valid && !tmo_err && !activity && !both_high) |=> (st_q.idle_cnt == '0))
        else $error("idle count not restarted"); // R10

    AST_ACTIVITY_VALIDATES: assert property (@(posedge clk) disable iff (rst)
        (run && !clear && !tmo_err && activity) |=> valid)
        else $error("activity did not validate"); // R8

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import bbw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int IDLE_CYC    = 1_000_000,
    parameter int TMO_CYC     = 2_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic soft_rst,
    input  logic sda_in,
    input  logic scl_in,
    input  logic free_clr,
    output logic busy,
    output logic bus_free_event,
    output logic busy_valid,
    output logic valid_timeout
);

    logic [NUM_LINES-1:0] line_raw;
    logic [NUM_LINES-1:0] line_flt;

    assign line_raw[LINE_SDA] = sda_in;
    assign line_raw[LINE_SCL] = scl_in;

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        bbw_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN),
            .RST_VAL     (1'b1)
        ) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (line_raw[gi]),
            .dout (line_flt[gi])
        );
    end

    bus_cond_t cond;

    bbw_cond_detect u_det (
        .clk  (clk),
        .rst  (rst),
        .sda  (line_flt[LINE_SDA]),
        .scl  (line_flt[LINE_SCL]),
        .cond (cond)
    );

    trk_state_t st_d, st_q;
    logic tracking;
    logic busy_set;
    logic vc_clear;
    logic vc_activity;

    assign tracking    = en && !soft_rst && !st_q.seed_pend;
    assign busy_set    = cond.start || cond.hold_low;
    assign vc_clear    = !en || soft_rst;
    assign vc_activity = busy_set || cond.stop;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.busy      = 1'b0;
            st_d.free_evt  = 1'b0;
            st_d.seed_pend = 1'b1;
        end else if (soft_rst) begin
            st_d.busy      = 1'b0;
            st_d.free_evt  = 1'b0;
            st_d.seed_pend = 1'b1;
        end else if (st_q.seed_pend) begin
            // Only SDA low with SCL high reads as an owned bus
            st_d.busy      = !line_flt[LINE_SDA] && line_flt[LINE_SCL];
            st_d.seed_pend = 1'b0;
        end else begin
            if (free_clr) begin
                st_d.free_evt = 1'b0;
            end
            if (cond.stop) begin
                st_d.busy     = 1'b0;
                st_d.free_evt = 1'b1;
            end else if (busy_set) begin
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.busy      <= 1'b0;
            st_q.free_evt  <= 1'b0;
            st_q.seed_pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    bbw_valid_ctrl #(
        .IDLE_CYC (IDLE_CYC),
        .TMO_CYC  (TMO_CYC)
    ) u_valid (
        .clk       (clk),
        .rst       (rst),
        .clear     (vc_clear),
        .run       (tracking),
        .activity  (vc_activity),
        .both_high (cond.both_high),
        .valid     (busy_valid),
        .tmo_err   (valid_timeout)
    );

    assign busy           = st_q.busy;
    assign bus_free_event = st_q.free_evt;

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!busy && !bus_free_event && !busy_valid && !valid_timeout))
        else $error("outputs active while disabled"); // R1

    AST_SEED_FROM_LINES: assert property (@(posedge clk) disable iff (rst)
        (en && !soft_rst && st_q.seed_pend) |=>
            (busy == ($past(!line_flt[LINE_SDA]) && $past(line_flt[LINE_SCL]))))
        else $error("busy seed mismatch"); // R2

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (tracking && cond.start) |=> busy)
        else $error("START did not set busy"); // R3

    AST_STOP_FREES: assert property (@(posedge clk) disable iff (rst)
        (tracking && cond.stop) |=> (!busy && bus_free_event))
        else $error("STOP did not free the bus"); // R5

    AST_FREE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (bus_free_event && en && !soft_rst && !free_clr) |=> bus_free_event)
        else $error("free flag dropped without clear"); // R6

    AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!bus_free_event && !busy_valid && !valid_timeout))
        else $error("soft reset left flags set"); // R7

endmodule

// File: tb/i2c_bus_watch_tb_top.sv
module i2c_bus_watch_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC_N     = 2;
    localparam int FILT_N     = 3;
    localparam int IDLE_N     = 40;
    localparam int TMO_N      = 200;
    localparam int WDOG_CYC   = 100_000;

    logic clk = 1'b0;
    logic rst, en, soft_rst, sda_in, scl_in, free_clr;
    logic busy, bus_free_event, busy_valid, valid_timeout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_bus_watch #(
        .SYNC_STAGES (SYNC_N),
        .FILT_LEN    (FILT_N),
        .IDLE_CYC    (IDLE_N),
        .TMO_CYC     (TMO_N)
    ) dut_i (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .soft_rst       (soft_rst),
        .sda_in         (sda_in),
        .scl_in         (scl_in),
        .free_clr       (free_clr),
        .busy           (busy),
        .bus_free_event (bus_free_event),
        .busy_valid     (busy_valid),
        .valid_timeout  (valid_timeout)
    );

    typedef struct {
        string tag;
        logic  b;
        logic  v;
        logic  f;
        logic  e;
    } exp_item_t;

    exp_item_t exp_q[$];

    // Monitor: compare each queued expectation at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            checks++;
            if ({busy, busy_valid, bus_free_event, valid_timeout} !== {it.b, it.v, it.f, it.e}) begin
                errors++;
                $display("FAIL %s: busy/valid/free/tmo actual %b%b%b%b expected %b%b%b%b",
                         it.tag, busy, busy_valid, bus_free_event, valid_timeout,
                         it.b, it.v, it.f, it.e);
            end
        end
    end

    task automatic expect_st(input string tag, input logic b, input logic v,
                             input logic f, input logic e);
        @(posedge clk);
        exp_q.push_back('{tag, b, v, f, e});
        @(negedge clk);
        #1;
    endtask

    task automatic set_lines(input logic s, input logic c);
        @(negedge clk);
        sda_in = s;
        scl_in = c;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pulse_srst();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        free_clr = 1'b1;
        @(negedge clk);
        free_clr = 1'b0;
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 1'b0; soft_rst = 1'b0;
        sda_in = 1'b1; scl_in = 1'b1; free_clr = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state and disabled block ignores START
        expect_st("R1 reset", 0, 0, 0, 0);
        set_lines(0, 1);
        settle(10);
        expect_st("R1 disabled START", 0, 0, 0, 0);
        set_lines(1, 1);
        settle(10);

        // R2: enable with idle lines seeds busy=0
        @(negedge clk);
        en = 1'b1;
        settle(3);
        expect_st("R2 enable seed 11", 0, 0, 0, 0);

        // R2: soft reset seeds from every line combination
        set_lines(0, 0); settle(12); pulse_srst(); settle(3);
        expect_st("R2 seed 00", 0, 0, 0, 0);
        set_lines(1, 0); settle(12); pulse_srst(); settle(3);
        expect_st("R2 seed 10", 0, 0, 0, 0);
        set_lines(0, 1); settle(12); pulse_srst(); settle(3);
        expect_st("R2 seed 01 busy, R8 valid", 1, 1, 0, 0);
        set_lines(1, 1); settle(12); pulse_srst(); settle(3);
        expect_st("R2 seed 11, R7 cleared", 0, 0, 0, 0);

        // R9: idle interval grants validity
        settle(30);
        expect_st("R9 before idle interval", 0, 0, 0, 0);
        settle(15);
        expect_st("R9 after idle interval", 0, 1, 0, 0);

        // R10: a low SCL pulse restarts the idle count
        pulse_srst();
        settle(25);
        set_lines(1, 0); settle(10);
        set_lines(1, 1); settle(30);
        expect_st("R10 idle restarted", 0, 0, 0, 0);
        settle(25);
        expect_st("R10 valid after full interval", 0, 1, 0, 0);

        // R3 / R8: START validates and sets busy
        pulse_srst();
        settle(10);
        set_lines(0, 1); settle(10);
        expect_st("R3 START sets busy, R8 valid", 1, 1, 0, 0);

        // R5: STOP clears busy and raises free flag
        set_lines(1, 1); settle(10);
        expect_st("R5 STOP", 0, 1, 1, 0);
        settle(20);
        expect_st("R6 free sticky", 0, 1, 1, 0);
        pulse_clr();
        expect_st("R6 free cleared", 0, 1, 0, 0);

        // R13: one-cycle SDA glitch is ignored
        @(negedge clk); sda_in = 1'b0;
        @(negedge clk); sda_in = 1'b1;
        settle(10);
        expect_st("R13 glitch ignored", 0, 1, 0, 0);

        // R12: simultaneous change is neither STOP nor START
        set_lines(1, 0); settle(10);
        set_lines(0, 0); settle(10);
        set_lines(1, 1); settle(10);
        expect_st("R12 joint rise not STOP", 0, 1, 0, 0);
        set_lines(0, 0); settle(10);
        expect_st("R12 joint fall not START", 0, 1, 0, 0);

        // R4: SCL rising while SDA low sets busy without START
        set_lines(0, 1); settle(10);
        expect_st("R4 ack-like level", 1, 1, 0, 0);

        // R6: clear in the same cycle as STOP, set wins
        set_lines(1, 1);
        repeat (SYNC_N + FILT_N) @(posedge clk);
        @(negedge clk); free_clr = 1'b1;
        @(negedge clk); free_clr = 1'b0;
        expect_st("R6 set wins over clear", 0, 1, 1, 0);
        pulse_clr();
        expect_st("R6 clear after collision", 0, 1, 0, 0);

        // R13: exact latency of a line change
        set_lines(0, 1);
        repeat (SYNC_N + FILT_N - 1) @(posedge clk);
        expect_st("R13 one cycle before latency", 0, 1, 0, 0);
        expect_st("R13 at latency", 1, 1, 0, 0);
        set_lines(1, 1); settle(10);
        pulse_clr();

        // R11: timeout without activity or idle lines
        set_lines(1, 0); settle(10);
        pulse_srst();
        settle(TMO_N + 20);
        expect_st("R11 timeout raised", 0, 0, 0, 1);
        set_lines(1, 1); settle(10);
        set_lines(0, 1); settle(10);
        expect_st("R11 busy tracks, valid stays low", 1, 0, 0, 1);
        pulse_srst();
        settle(5);
        expect_st("R7 soft reset clears timeout", 1, 1, 0, 0);

        // R1: disable drops everything and ignores STOP
        @(negedge clk); en = 1'b0;
        settle(3);
        expect_st("R1 disabled outputs", 0, 0, 0, 0);
        set_lines(1, 1); settle(10);
        expect_st("R1 disabled STOP ignored", 0, 0, 0, 0);

        settle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule